// File: doc/BRIEF.md
# Packet Buffer Allocation and Queue Command Engine

This block manages the packet-buffer memory of an Ethernet controller. Software writes a command byte, and the engine updates its buffer bookkeeping. That bookkeeping is an occupancy bitmap with one bit per packet buffer, plus three packet-number queues: a receive queue, a transmit queue and a transmit-completion queue. Only the top three bits of the byte select the action. The actions are: nothing, allocate a buffer for transmit, clear all bookkeeping, drop the receive head, drop the receive head and free its buffer, free the buffer named by the packet-number input, queue that packet for transmit, and empty both transmit-side queues.

The engine also holds the interrupt status byte and the interrupt enable byte, and drives a level interrupt. Software clears status bits with an acknowledge write. Acknowledging the transmit-completion bit also retires one entry from the completion queue. Receive arrivals, finished transmissions and other interrupt events come in on dedicated input ports. The packet data itself, the MAC datapaths and the register address decode are all outside this block.

All state changes take effect on the rising clock edge that samples the strobe. Every output is visible in the cycle after that edge.

Top module: `pkt_mmu_engine`

## Requirements
- R1: After reset the occupancy bitmap is 0, all three queues are empty, the allocation result is 0x00, the status and enable bytes are 0x00 and the interrupt is low.
- R2: The action comes from bits 7:5 of the command byte alone, and bits 4:0 are ignored. Code 0 changes nothing. At most one action runs per command.
- R3: Code 1 clears status bit 3, then looks for the lowest-numbered free buffer. If one is free, it marks that buffer as used, loads its number into the allocation result with bit 7 at 0, and sets status bit 3. If none is free, the allocation result becomes 0x80.
- R4: Code 2 clears the bitmap, the allocation result and all three queues. A queue push in the same cycle lands in the queue after the clear.
- R5: Code 7 empties the transmit queue and the completion queue and leaves the receive queue and the bitmap unchanged.
- R6: Code 3 removes the receive head. Code 4 frees the receive head's buffer and then removes the head. Either code on an empty receive queue changes nothing.
- R7: Code 5 frees the buffer given on the packet-number input. Code 6 appends that number to the transmit queue, and the number is dropped if the queue is full.
- R8: An acknowledge write clears the status bits selected by its data ANDed with 0xD6, so bits 0, 3 and 5 are never cleared this way. Event inputs set status bits 1, 2, 4, 5, 6 and 7. A set in the same cycle as a clear wins.
- R9: An acknowledge with data bit 1 set removes the head of the completion queue, if the queue is not empty.
- R10: A mask write loads the whole byte into the enable register. The interrupt output is high exactly when status AND enable is non-zero, and it follows every status or enable change in the same cycle.
- R11: The receive and completion push ports append a packet number when their queue has room and drop it otherwise. A pop and a push in the same cycle apply the pop first. A completion push always sets status bit 1.
- R12: Status bit 0 reads 1 exactly when the receive queue is not empty. Each queue's head output reads 0 when that queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command byte strobe |
| cmdByte | input | 8 | Command byte; bits 7:5 select the action |
| pktNum | input | PW | Packet number used by the free and enqueue actions |
| ackValid | input | 1 | Interrupt acknowledge strobe |
| ackByte | input | 8 | Acknowledge data |
| maskValid | input | 1 | Interrupt enable write strobe |
| maskByte | input | 8 | New interrupt enable byte |
| intEvents | input | 8 | One-cycle interrupt event pulses |
| rxPushValid | input | 1 | Receive arrival strobe |
| rxPushNum | input | PW | Packet number of the received frame |
| txDonePushValid | input | 1 | Transmission-finished strobe |
| txDonePushNum | input | PW | Packet number of the finished transmission |
| allocResult | output | 8 | Allocation result; bit 7 set means no buffer was granted |
| allocMap | output | NPKT | Buffer occupancy bitmap |
| rxCount | output | CW | Receive queue fill |
| rxHead | output | PW | Receive queue head |
| txCount | output | CW | Transmit queue fill |
| txHead | output | PW | Transmit queue head |
| txDoneCount | output | CW | Completion queue fill |
| txDoneHead | output | PW | Completion queue head |
| intStatus | output | 8 | Interrupt status byte |
| intMask | output | 8 | Interrupt enable byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the places where two sources touch the same state in one cycle. These are a push into a full queue alongside a pop, a clear-all command alongside a push, and an acknowledge alongside an event on the same status bit. A design that ordered these the wrong way would lose or keep one packet number, or would drop an event. Allocation is driven until every buffer is taken and then once more. A design that got this wrong would return a taken buffer or fail to report 0x80. Pops and pop-with-free are issued on an empty receive queue, where a faulty design would free a buffer on a stale head. Acknowledges are written with bits 0, 3 and 5 set, and any of those bits clearing would be caught as a fault.

// File: rtl/pkt_mmu_pkg.sv
package pkt_mmu_pkg;

  localparam logic [7:0] ACK_CLEARABLE = 8'hD6;
  localparam logic [7:0] EVT_SETTABLE  = 8'hF6;
  localparam logic [7:0] ALLOC_PENDING = 8'h80;
  localparam int BIT_RXQ    = 0;
  localparam int BIT_TXDONE = 1;
  localparam int BIT_ALLOC  = 3;

  localparam int Q_RX   = 0;
  localparam int Q_TX   = 1;
  localparam int Q_DONE = 2;
  localparam int NUM_Q  = 3;

  typedef enum logic [2:0] {
    CMD_NOP       = 3'd0,
    CMD_ALLOC     = 3'd1,
    CMD_WIPE      = 3'd2,
    CMD_RX_DROP   = 3'd3,
    CMD_RX_FREE   = 3'd4,
    CMD_FREE_PKT  = 3'd5,
    CMD_TX_ENQ    = 3'd6,
    CMD_TX_FLUSH  = 3'd7
  } mmuCmd_e;

  typedef struct packed {
    logic       alloc;
    logic       wipe;
    logic       rxPop;
    logic       rxFree;
    logic       pktFree;
    logic       txEnq;
    logic       txFlush;
    logic       ack;
    logic [7:0] ackClr;
    logic       doneAckPop;
    logic       maskLoad;
    logic [7:0] maskVal;
  } mmuStrobe_t;

endpackage

// File: rtl/pkt_mmu_ctrl.sv
module pkt_mmu_ctrl
  import pkt_mmu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdByte,
  input  logic       ackValid,
  input  logic [7:0] ackByte,
  input  logic       maskValid,
  input  logic [7:0] maskByte,
  output mmuStrobe_t strb
);

  mmuCmd_e cmdCode;
  assign cmdCode = mmuCmd_e'(cmdByte[7:5]);

  always_comb begin
    strb = '0;
    if (cmdValid) begin
      case (cmdCode)
        CMD_NOP:      ;
        CMD_ALLOC:    strb.alloc   = 1'b1;
        CMD_WIPE:     strb.wipe    = 1'b1;
        CMD_RX_DROP:  strb.rxPop   = 1'b1;
        CMD_RX_FREE: begin
          strb.rxPop  = 1'b1;
          strb.rxFree = 1'b1;
        end
        CMD_FREE_PKT: strb.pktFree = 1'b1;
        CMD_TX_ENQ:   strb.txEnq   = 1'b1;
        CMD_TX_FLUSH: strb.txFlush = 1'b1;
        default:      ;
      endcase
    end
    strb.ack        = ackValid;
    strb.ackClr     = ackValid ? (ackByte & ACK_CLEARABLE) : 8'h00;
    strb.doneAckPop = ackValid & ackByte[BIT_TXDONE];
    strb.maskLoad   = maskValid;
    strb.maskVal    = maskByte;
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.alloc, strb.wipe, strb.rxPop, strb.pktFree, strb.txEnq, strb.txFlush})); // R2
  AST_NOP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid || cmdByte[7:5] == 3'd0) |->
      !(strb.alloc | strb.wipe | strb.rxPop | strb.pktFree | strb.txEnq | strb.txFlush)); // R2

endmodule

// File: rtl/pkt_mmu_queue.sv
module pkt_mmu_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clear,
  input  logic          pop,
  input  logic          push,
  input  logic [W-1:0]  pushData,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  logic [W-1:0]  slots    [DEPTH];
  logic [W-1:0]  slotsNxt [DEPTH];
  logic [CW-1:0] fill, fillNxt;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) slotsNxt[i] = slots[i];
    fillNxt = clear ? '0 : fill;
    if (pop && fillNxt != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) slotsNxt[i] = slots[i + 1];
      fillNxt = fillNxt - ONE_C;
    end
    if (push && fillNxt < FULL_C) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) == fillNxt) slotsNxt[i] = pushData;
      end
      fillNxt = fillNxt + ONE_C;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fill <= '0;
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else begin
      fill <= fillNxt;
      for (int i = 0; i < DEPTH; i++) slots[i] <= slotsNxt[i];
    end
  end

  assign head  = (fill != '0) ? slots[0] : '0;
  assign count = fill;

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && !pop && push && fill == FULL_C) |=> (fill == FULL_C && $stable(head))); // R11
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && pop && !push && fill == '0) |=> (fill == '0)); // R6
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (clear && !push) |=> (fill == '0)); // R4

endmodule

// File: rtl/pkt_mmu_datapath.sv
module pkt_mmu_datapath
  import pkt_mmu_pkg::*;
#(
  parameter int NPKT   = 4,
  parameter int QDEPTH = 4,
  parameter int PW     = $clog2(NPKT),
  parameter int CW     = $clog2(QDEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  mmuStrobe_t      strb,
  input  logic [PW-1:0]   pktNum,
  input  logic [7:0]      intEvents,
  input  logic            rxPushValid,
  input  logic [PW-1:0]   rxPushNum,
  input  logic            txDonePushValid,
  input  logic [PW-1:0]   txDonePushNum,
  output logic [7:0]      allocResult,
  output logic [NPKT-1:0] allocMap,
  output logic [CW-1:0]   rxCount,
  output logic [PW-1:0]   rxHead,
  output logic [CW-1:0]   txCount,
  output logic [PW-1:0]   txHead,
  output logic [CW-1:0]   txDoneCount,
  output logic [PW-1:0]   txDoneHead,
  output logic [7:0]      intStatus,
  output logic [7:0]      intMask,
  output logic            irq
);

  logic [NUM_Q-1:0] qClear, qPop, qPush;
  logic [PW-1:0]    qData  [NUM_Q];
  logic [PW-1:0]    qHead  [NUM_Q];
  logic [CW-1:0]    qCount [NUM_Q];

  assign qClear[Q_RX]   = strb.wipe;
  assign qPop[Q_RX]     = strb.rxPop;
  assign qPush[Q_RX]    = rxPushValid;
  assign qData[Q_RX]    = rxPushNum;
  assign qClear[Q_TX]   = strb.wipe | strb.txFlush;
  assign qPop[Q_TX]     = 1'b0;
  assign qPush[Q_TX]    = strb.txEnq;
  assign qData[Q_TX]    = pktNum;
  assign qClear[Q_DONE] = strb.wipe | strb.txFlush;
  assign qPop[Q_DONE]   = strb.doneAckPop;
  assign qPush[Q_DONE]  = txDonePushValid;
  assign qData[Q_DONE]  = txDonePushNum;

  generate
    for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
      pkt_mmu_queue #(.DEPTH(QDEPTH), .W(PW), .CW(CW)) u_queue (
        .clk      (clk),
        .rstN     (rstN),
        .clear    (qClear[g]),
        .pop      (qPop[g]),
        .push     (qPush[g]),
        .pushData (qData[g]),
        .head     (qHead[g]),
        .count    (qCount[g])
      );
    end
  endgenerate

  logic [NPKT-1:0] pktMap, pktMapNxt;
  logic [7:0]      allocReg, allocNxt;
  logic [7:0]      sticky, stickyNxt;
  logic [7:0]      maskReg;
  logic            freeFound;
  logic [PW-1:0]   freeIdx;

  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = NPKT - 1; i >= 0; i--) begin
      if (!pktMap[i]) begin
        freeFound = 1'b1;
        freeIdx   = PW'(i);
      end
    end
  end

  always_comb begin
    pktMapNxt = pktMap;
    allocNxt  = allocReg;
    if (strb.wipe) begin
      pktMapNxt = '0;
      allocNxt  = 8'h00;
    end
    if (strb.alloc) begin
      if (freeFound) begin
        pktMapNxt[freeIdx] = 1'b1;
        allocNxt = {{(8 - PW){1'b0}}, freeIdx};
      end else begin
        allocNxt = ALLOC_PENDING;
      end
    end
    if (strb.rxFree && qCount[Q_RX] != '0) pktMapNxt[qHead[Q_RX]] = 1'b0;
    if (strb.pktFree) pktMapNxt[pktNum] = 1'b0;
  end

  always_comb begin
    stickyNxt = sticky & ~strb.ackClr;
    if (strb.alloc) stickyNxt[BIT_ALLOC] = freeFound;
    stickyNxt = stickyNxt | (intEvents & EVT_SETTABLE);
    if (txDonePushValid) stickyNxt[BIT_TXDONE] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktMap   <= '0;
      allocReg <= 8'h00;
      sticky   <= 8'h00;
      maskReg  <= 8'h00;
    end else begin
      pktMap   <= pktMapNxt;
      allocReg <= allocNxt;
      sticky   <= stickyNxt;
      if (strb.maskLoad) maskReg <= strb.maskVal;
    end
  end

  assign allocResult = allocReg;
  assign allocMap    = pktMap;
  assign rxCount     = qCount[Q_RX];
  assign rxHead      = qHead[Q_RX];
  assign txCount     = qCount[Q_TX];
  assign txHead      = qHead[Q_TX];
  assign txDoneCount = qCount[Q_DONE];
  assign txDoneHead  = qHead[Q_DONE];
  assign intStatus   = {sticky[7:1], qCount[Q_RX] != '0};
  assign intMask     = maskReg;
  assign irq         = |(intStatus & intMask);

  AST_ALLOC_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.alloc && !(&pktMap)) |=> (!allocResult[7] && intStatus[BIT_ALLOC] && allocMap[allocResult[PW-1:0]])); // R3
  AST_ALLOC_EXHAUSTED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.alloc && (&pktMap)) |=> (allocResult == 8'h80 && !intStatus[BIT_ALLOC])); // R3
  AST_WIPE_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wipe && !rxPushValid && !txDonePushValid) |=>
      (allocMap == '0 && allocResult == 8'h00 && rxCount == '0 && txCount == '0 && txDoneCount == '0)); // R4
  AST_FLUSH_KEEPS_RX: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txFlush && !rxPushValid) |=> (rxCount == $past(rxCount) && allocMap == $past(allocMap))); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.ack |=> ((intStatus & $past(strb.ackClr) & ~$past(intEvents) & 8'hD4) == 8'h00)); // R8
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskLoad |=> (intMask == $past(strb.maskVal))); // R10

endmodule

// File: rtl/pkt_mmu_engine.sv
module pkt_mmu_engine
  import pkt_mmu_pkg::*;
#(
  parameter  int NPKT   = 4,
  parameter  int QDEPTH = 4,
  localparam int PW     = $clog2(NPKT),
  localparam int CW     = $clog2(QDEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [7:0]      cmdByte,
  input  logic [PW-1:0]   pktNum,
  input  logic            ackValid,
  input  logic [7:0]      ackByte,
  input  logic            maskValid,
  input  logic [7:0]      maskByte,
  input  logic [7:0]      intEvents,
  input  logic            rxPushValid,
  input  logic [PW-1:0]   rxPushNum,
  input  logic            txDonePushValid,
  input  logic [PW-1:0]   txDonePushNum,
  output logic [7:0]      allocResult,
  output logic [NPKT-1:0] allocMap,
  output logic [CW-1:0]   rxCount,
  output logic [PW-1:0]   rxHead,
  output logic [CW-1:0]   txCount,
  output logic [PW-1:0]   txHead,
  output logic [CW-1:0]   txDoneCount,
  output logic [PW-1:0]   txDoneHead,
  output logic [7:0]      intStatus,
  output logic [7:0]      intMask,
  output logic            irq
);

  mmuStrobe_t strb;

  pkt_mmu_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdByte   (cmdByte),
    .ackValid  (ackValid),
    .ackByte   (ackByte),
    .maskValid (maskValid),
    .maskByte  (maskByte),
    .strb      (strb)
  );

  pkt_mmu_datapath #(.NPKT(NPKT), .QDEPTH(QDEPTH), .PW(PW), .CW(CW)) u_datapath (
    .clk             (clk),
    .rstN            (rstN),
    .strb            (strb),
    .pktNum          (pktNum),
    .intEvents       (intEvents),
    .rxPushValid     (rxPushValid),
    .rxPushNum       (rxPushNum),
    .txDonePushValid (txDonePushValid),
    .txDonePushNum   (txDonePushNum),
    .allocResult     (allocResult),
    .allocMap        (allocMap),
    .rxCount         (rxCount),
    .rxHead          (rxHead),
    .txCount         (txCount),
    .txHead          (txHead),
    .txDoneCount     (txDoneCount),
    .txDoneHead      (txDoneHead),
    .intStatus       (intStatus),
    .intMask         (intMask),
    .irq             (irq)
  );

endmodule

// File: tb/test_pkt_mmu_engine.sv
`timescale 1ns/1ps
module test_pkt_mmu_engine;

  localparam int NPKT = 4;
  localparam int QD   = 4;
  localparam int PW   = 2;
  localparam int CW   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [7:0] cmdByte = 8'h00;
  logic [PW-1:0] pktNum = '0;
  logic ackValid = 1'b0;
  logic [7:0] ackByte = 8'h00;
  logic maskValid = 1'b0;
  logic [7:0] maskByte = 8'h00;
  logic [7:0] intEvents = 8'h00;
  logic rxPushValid = 1'b0;
  logic [PW-1:0] rxPushNum = '0;
  logic txDonePushValid = 1'b0;
  logic [PW-1:0] txDonePushNum = '0;

  logic [7:0] allocResult;
  logic [NPKT-1:0] allocMap;
  logic [CW-1:0] rxCount, txCount, txDoneCount;
  logic [PW-1:0] rxHead, txHead, txDoneHead;
  logic [7:0] intStatus, intMask;
  logic irq;

  always #2.5 clk = ~clk;

  pkt_mmu_engine #(.NPKT(NPKT), .QDEPTH(QD)) i_pkt_mmu_engine (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte), .pktNum(pktNum),
    .ackValid(ackValid), .ackByte(ackByte), .maskValid(maskValid), .maskByte(maskByte),
    .intEvents(intEvents), .rxPushValid(rxPushValid), .rxPushNum(rxPushNum),
    .txDonePushValid(txDonePushValid), .txDonePushNum(txDonePushNum),
    .allocResult(allocResult), .allocMap(allocMap), .rxCount(rxCount), .rxHead(rxHead),
    .txCount(txCount), .txHead(txHead), .txDoneCount(txDoneCount), .txDoneHead(txDoneHead),
    .intStatus(intStatus), .intMask(intMask), .irq(irq)
  );

  int nRun = 0;
  int nFail = 0;

  // reference model state
  logic [7:0] mAlloc = 8'h00;
  logic [NPKT-1:0] mMap = '0;
  logic [7:0] mSticky = 8'h00;
  logic [7:0] mMask = 8'h00;
  int rxQ[$];
  int txQ[$];
  int tdQ[$];

  task automatic check(string req, string phase, int got, int exp);
    nRun++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s (%s): got %0h expected %0h", req, phase, got, exp);
    end
  endtask

  function automatic logic [7:0] mStatus();
    return {mSticky[7:1], rxQ.size() != 0};
  endfunction

  task automatic compareAll(string phase);
    check("R3 allocResult", phase, int'(allocResult), int'(mAlloc));
    check("R3 allocMap", phase, int'(allocMap), int'(mMap));
    check("R11 rxCount", phase, int'(rxCount), rxQ.size());
    check("R6 rxHead", phase, int'(rxHead), rxQ.size() != 0 ? rxQ[0] : 0);
    check("R7 txCount", phase, int'(txCount), txQ.size());
    check("R7 txHead", phase, int'(txHead), txQ.size() != 0 ? txQ[0] : 0);
    check("R9 txDoneCount", phase, int'(txDoneCount), tdQ.size());
    check("R9 txDoneHead", phase, int'(txDoneHead), tdQ.size() != 0 ? tdQ[0] : 0);
    check("R8 intStatus", phase, int'(intStatus), int'(mStatus()));
    check("R12 rx status bit", phase, int'(intStatus[0]), int'(rxQ.size() != 0));
    check("R10 intMask", phase, int'(intMask), int'(mMask));
    check("R10 irq", phase, int'(irq), int'((mStatus() & mMask) != 8'h00));
  endtask

  task automatic modelStep();
    int idx;
    if (cmdValid) begin
      case (cmdByte[7:5])
        3'd1: begin
          idx = -1;
          for (int i = 0; i < NPKT; i++) if (!mMap[i] && idx < 0) idx = i;
          mSticky[3] = 1'b0;
          if (idx >= 0) begin
            mMap[idx] = 1'b1;
            mAlloc = 8'(idx);
            mSticky[3] = 1'b1;
          end else mAlloc = 8'h80;
        end
        3'd2: begin
          mMap = '0; mAlloc = 8'h00;
          rxQ.delete(); txQ.delete(); tdQ.delete();
        end
        3'd3: if (rxQ.size() != 0) void'(rxQ.pop_front());
        3'd4: if (rxQ.size() != 0) begin
          mMap[rxQ[0]] = 1'b0;
          void'(rxQ.pop_front());
        end
        3'd5: mMap[pktNum] = 1'b0;
        3'd6: if (txQ.size() < QD) txQ.push_back(int'(pktNum));
        3'd7: begin txQ.delete(); tdQ.delete(); end
        default: ;
      endcase
    end
    if (ackValid) begin
      mSticky = mSticky & ~(ackByte & 8'hD6);
      if (ackByte[1] && tdQ.size() != 0) void'(tdQ.pop_front());
    end
    if (maskValid) mMask = maskByte;
    mSticky = mSticky | (intEvents & 8'hF6);
    if (rxPushValid && rxQ.size() < QD) rxQ.push_back(int'(rxPushNum));
    if (txDonePushValid) begin
      if (tdQ.size() < QD) tdQ.push_back(int'(txDonePushNum));
      mSticky[1] = 1'b1;
    end
  endtask

  task automatic tick(string phase);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll(phase);
    cmdValid = 1'b0; ackValid = 1'b0; maskValid = 1'b0; intEvents = 8'h00;
    rxPushValid = 1'b0; txDonePushValid = 1'b0;
  endtask

  task automatic cmd(logic [7:0] b, logic [PW-1:0] p, string phase);
    cmdValid = 1'b1; cmdByte = b; pktNum = p;
    tick(phase);
  endtask

  initial begin
    #(200000 * 5);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1", "reset allocResult", int'(allocResult), 0);
    check("R1", "reset map", int'(allocMap), 0);
    check("R1", "reset counts", int'(rxCount) + int'(txCount) + int'(txDoneCount), 0);
    check("R1", "reset status", int'(intStatus), 0);
    check("R1", "reset mask/irq", int'(intMask) + int'(irq), 0);

    // R2: code 0 with low bits set does nothing
    cmd(8'h1F, 2'd3, "R2 no-op");
    // R3: allocate until exhausted, low bits of command ignored
    cmd(8'h20, 0, "R3 alloc 0");
    cmd(8'h3F, 0, "R3 alloc 1");
    maskValid = 1'b1; maskByte = 8'h08;
    tick("R10 mask alloc bit");
    cmd(8'h20, 0, "R3 alloc 2");
    cmd(8'h20, 0, "R3 alloc 3");
    cmd(8'h20, 0, "R3 alloc exhausted");
    // R7: free and reallocate, enqueue until full
    cmd(8'hA0, 2'd2, "R7 free pkt 2");
    cmd(8'h20, 0, "R3 realloc lowest");
    for (int i = 0; i < 5; i++) cmd(8'hC0, PW'(i), "R7 tx enqueue");
    // R11: receive and completion pushes
    for (int i = 0; i < 3; i++) begin
      rxPushValid = 1'b1; rxPushNum = PW'(i + 1);
      txDonePushValid = (i < 2); txDonePushNum = PW'(3 - i);
      tick("R11 pushes");
    end
    // R5: flush transmit side only
    cmd(8'hE0, 0, "R5 tx flush");
    // R6: pop-and-free, plain pop
    cmd(8'h80, 0, "R6 pop and free");
    cmd(8'h60, 0, "R6 pop");
    cmd(8'h60, 0, "R6 pop last");
    cmd(8'h60, 0, "R6 pop empty");
    cmd(8'h80, 0, "R6 pop-free empty");
    // R11: full rx queue, push with and without pop
    for (int i = 0; i < 5; i++) begin rxPushValid = 1'b1; rxPushNum = PW'(i); tick("R11 fill rx"); end
    cmdValid = 1'b1; cmdByte = 8'h60; rxPushValid = 1'b1; rxPushNum = 2'd3;
    tick("R11 pop then push full");
    // R8/R10: events, acknowledge, set-wins
    maskValid = 1'b1; maskByte = 8'hFF;
    tick("R10 mask all");
    intEvents = 8'hFF;
    tick("R8 events");
    ackValid = 1'b1; ackByte = 8'hFF;
    tick("R8 ack all");
    ackValid = 1'b1; ackByte = 8'h44; intEvents = 8'h04;
    tick("R8 set wins");
    // R9: acknowledge pops completion queue
    for (int i = 0; i < 2; i++) begin txDonePushValid = 1'b1; txDonePushNum = PW'(i); tick("R9 done push"); end
    ackValid = 1'b1; ackByte = 8'h02;
    tick("R9 ack pops done");
    ackValid = 1'b1; ackByte = 8'h02; txDonePushValid = 1'b1; txDonePushNum = 2'd2;
    tick("R9 ack pop with push");
    maskValid = 1'b1; maskByte = 8'h00;
    tick("R10 mask off");
    // R4: wipe with a receive push in the same cycle
    cmdValid = 1'b1; cmdByte = 8'h40; rxPushValid = 1'b1; rxPushNum = 2'd1;
    tick("R4 wipe with push");
    cmd(8'h5A, 0, "R4 wipe");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      cmdValid = ($urandom_range(0, 2) == 0);
      cmdByte = 8'($urandom);
      pktNum = PW'($urandom);
      ackValid = ($urandom_range(0, 5) == 0);
      ackByte = 8'($urandom);
      maskValid = ($urandom_range(0, 9) == 0);
      maskByte = 8'($urandom);
      intEvents = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h00;
      rxPushValid = ($urandom_range(0, 3) == 0);
      rxPushNum = PW'($urandom);
      txDonePushValid = ($urandom_range(0, 4) == 0);
      txDonePushNum = PW'($urandom);
      tick("R2 random mix");
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule